// File: doc/BRIEF.md
# Subroutine Call Bus Sequencer

This block produces the six bus cycles of an 8-bit processor's jump-to-subroutine instruction. A one-cycle `start` pulse in idle hands it the address of the opcode and the current stack pointer. It then drives the address, the write data and the read/write strobe for six consecutive cycles. It labels each cycle with its kind: opcode fetch, operand fetch, dummy read or stack push. It also captures the two target bytes from the read data. When the sequence ends it presents the new program counter and the updated stack pointer, and flags completion for one cycle.

The sequencer supports two cycle orderings, chosen by `mode_alt` during the opcode fetch. In the classic ordering, the dummy read and both pushes come between the two operand reads. The high target byte arrives last and goes straight into the program counter, so only the low byte needs holding. In the deferred-push ordering, both operand bytes are read before anything is written. An external agent can therefore cancel the instruction before memory changes. The price is holding both target bytes until the final push.

Top module: `jsr_call_seq`

## Requirements
- R1: After reset, `busy` and `done` are low, `rw_n` is 1 and `cyc_type` is 0 (idle).
- R2: With `mode_alt`=0 in the opcode cycle, the six cycles are opcode read at P, operand read at P+1, dummy read, push, push, and operand read at P+2. P is the `start_pc` value.
- R3: With `mode_alt`=1 in the opcode cycle, the six cycles are opcode read at P, operand read at P+1, operand read at P+2, dummy read, push, push.
- R4: Pushes are writes (`rw_n`=0) to address {0x01, SP}. The first push writes the high byte of P+2 at the starting SP, and the second writes its low byte at SP-1. SP wraps within the page, so 0x00 minus one gives 0xFF.
- R5: The dummy read has `rw_n`=1 and uses address {0x01, starting SP}.
- R6: In the cycle right after the sixth bus cycle, `done` is high for exactly one cycle and `busy` is low. `pc_out` then equals {byte read at P+2, byte read at P+1}, and `sp_out` equals the starting SP minus 2, modulo 256.
- R7: In the deferred-push ordering, no write occurs until both operand bytes have been read.
- R8: `mode_alt` is sampled only in the opcode cycle. Changing it later has no effect on the running sequence.
- R9: A `start` pulse while `busy` is high is ignored, together with its `start_pc` and `start_sp`.
- R10: `cyc_type` encodes idle as 0, opcode as 1, operand as 2, dummy read as 3 and push as 4.
- R11: Operand addresses P+1 and P+2 wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a call sequence (accepted only when idle) |
| start_pc | input | 16 | Address of the opcode |
| start_sp | input | 8 | Stack pointer at the start |
| mode_alt | input | 1 | 0 = classic ordering, 1 = deferred-push ordering |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data (valid on pushes) |
| rw_n | output | 1 | 1 = read, 0 = write |
| cyc_type | output | 3 | Cycle kind of the current bus cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion flag |
| pc_out | output | 16 | Program counter (call target after completion) |
| sp_out | output | 8 | Stack pointer |

## Verification
The bench uses the default 8-bit data width and stack page 0x01. At that size every starting stack pointer from 0x00 to 0xFF can be swept in both orderings. This covers the in-page wrap of the second push and of the final stack pointer. Program counters are derived from each stack value, with extra runs near 0xFFFF, so the operand addresses and the pushed return address also cross the 16-bit wrap. Every call toggles `mode_alt` after the opcode cycle, and many inject a stray `start`, which brings the sampling and ignore rules into every run.

// File: rtl/jsr_seq_pkg.sv
package jsr_seq_pkg;

  typedef enum logic [2:0] {
    CT_IDLE    = 3'd0,
    CT_OPCODE  = 3'd1,
    CT_OPERAND = 3'd2,
    CT_DUMMY   = 3'd3,
    CT_PUSH    = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    SL_NONE,
    SL_OPC,
    SL_TLO,
    SL_THI,
    SL_DUM,
    SL_PSH_H,
    SL_PSH_L
  } slot_e;

  localparam int STEPS  = 6;
  localparam int STEP_W = $clog2(STEPS);

  // Ordering tables: classic puts the high target read last,
  // deferred-push reads both target bytes before any write.
  function automatic slot_e slot_for(input logic alt, input logic [STEP_W-1:0] step);
    slot_e s;
    s = SL_NONE;
    if (!alt) begin
      case (step)
        3'd0: s = SL_OPC;
        3'd1: s = SL_TLO;
        3'd2: s = SL_DUM;
        3'd3: s = SL_PSH_H;
        3'd4: s = SL_PSH_L;
        3'd5: s = SL_THI;
        default: s = SL_NONE;
      endcase
    end else begin
      case (step)
        3'd0: s = SL_OPC;
        3'd1: s = SL_TLO;
        3'd2: s = SL_THI;
        3'd3: s = SL_DUM;
        3'd4: s = SL_PSH_H;
        3'd5: s = SL_PSH_L;
        default: s = SL_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic cyc_kind_e kind_of(input slot_e s);
    cyc_kind_e k;
    case (s)
      SL_OPC:             k = CT_OPCODE;
      SL_TLO, SL_THI:     k = CT_OPERAND;
      SL_DUM:             k = CT_DUMMY;
      SL_PSH_H, SL_PSH_L: k = CT_PUSH;
      default:            k = CT_IDLE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/jsr_seq_step.sv
module jsr_seq_step
  import jsr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              last,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  assign last = busy && (step == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          step <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/jsr_seq_decode.sv
module jsr_seq_decode
  import jsr_seq_pkg::*;
(
  input  logic              busy,
  input  logic              alt,
  input  logic [STEP_W-1:0] step,
  output slot_e             slot,
  output cyc_kind_e         kind
);
  always_comb begin
    slot = busy ? slot_for(alt, step) : SL_NONE;
    kind = kind_of(slot);
  end
endmodule

// File: rtl/jsr_seq_datapath.sv
module jsr_seq_datapath
  import jsr_seq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_pc,
  input  logic [DATA_W-1:0] load_sp,
  input  logic              alt,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] sp
);
  logic [DATA_W-1:0] tmp_lo, tmp_hi;
  logic              stack_cycle;

  assign stack_cycle = (slot == SL_DUM) || (slot == SL_PSH_H) || (slot == SL_PSH_L);
  assign addr        = stack_cycle ? {STACK_PAGE, sp} : pc;

  always_comb begin
    case (slot)
      SL_PSH_H: wdata = pc[ADDR_W-1:DATA_W];
      SL_PSH_L: wdata = pc[DATA_W-1:0];
      default:  wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      sp     <= '0;
      tmp_lo <= '0;
      tmp_hi <= '0;
    end else if (load) begin
      pc <= load_pc;
      sp <= load_sp;
    end else begin
      case (slot)
        SL_OPC: pc <= pc + 1'b1;
        SL_TLO: begin
          tmp_lo <= rdata;
          pc     <= pc + 1'b1;
        end
        SL_THI: begin
          if (alt) tmp_hi <= rdata;
          else     pc     <= {rdata, tmp_lo};
        end
        SL_PSH_H: sp <= sp - 1'b1;
        SL_PSH_L: begin
          sp <= sp - 1'b1;
          if (alt) pc <= {tmp_hi, tmp_lo};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/jsr_call_seq.sv
module jsr_call_seq
  import jsr_seq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [DATA_W-1:0] start_sp,
  input  logic              mode_alt,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw_n,
  output logic [2:0]        cyc_type,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out
);
  logic [STEP_W-1:0] step;
  logic              last;
  logic              mode_q;
  slot_e             slot;
  cyc_kind_e         kind;

  // Named events for the checker
  logic accept_fire, opc_fire, push_fire, oper_fire;
  assign accept_fire = start && !busy;
  assign opc_fire    = (slot == SL_OPC);
  assign push_fire   = (kind == CT_PUSH);
  assign oper_fire   = (kind == CT_OPERAND);

  jsr_seq_step u_step (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .step(step), .last(last), .done(done)
  );

  // Ordering is captured during the opcode cycle only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (opc_fire) mode_q <= mode_alt;
  end

  jsr_seq_decode u_dec (
    .busy(busy), .alt(mode_q), .step(step), .slot(slot), .kind(kind)
  );

  jsr_seq_datapath #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .load(accept_fire), .load_pc(start_pc), .load_sp(start_sp),
    .alt(mode_q), .slot(slot), .rdata(rdata),
    .addr(addr), .wdata(wdata), .pc(pc_out), .sp(sp_out)
  );

  assign rw_n     = !push_fire;
  assign cyc_type = kind;
endmodule

// File: rtl/jsr_call_seq_chk.sv
module jsr_call_seq_chk #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rw_n,
  input logic [2:0]        cyc_type,
  input logic              done,
  input logic              busy,
  input logic [DATA_W-1:0] sp_out,
  input logic              mode_q,
  input logic              push_fire
);
  logic [1:0] oper_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                oper_seen <= '0;
    else if (cyc_type == 3'd1)                 oper_seen <= '0;
    else if (cyc_type == 3'd2 && oper_seen != 2'd3) oper_seen <= oper_seen + 1'b1;
  end

  // R4: every write lands in the stack page
  a_r4_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R4: stack pointer steps down by one after each push
  a_r4_sp_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_out == $past(sp_out) - 1'b1);

  // R5: dummy cycle is a read in the stack page
  a_r5_dummy_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type == 3'd3 |-> rw_n && addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R6: completion flag is a single-cycle pulse while idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R7: deferred-push ordering writes only after both operand reads
  a_r7_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_n && mode_q) |-> oper_seen == 2'd2);

  // R10: only defined cycle codes appear
  a_r10_type_range: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type <= 3'd4);
endmodule

bind jsr_call_seq jsr_call_seq_chk #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n), .cyc_type(cyc_type),
  .done(done), .busy(busy), .sp_out(sp_out), .mode_q(mode_q), .push_fire(push_fire)
);

// File: tb/jsr_call_seq_bench.sv
module jsr_call_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_pc = '0;
  logic [7:0]  start_sp = '0;
  logic        mode_alt = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rw_n;
  logic [2:0]  cyc_type;
  logic        busy, done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  jsr_call_seq u_jsr_call_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .start_sp(start_sp), .mode_alt(mode_alt), .rdata(rdata),
    .addr(addr), .wdata(wdata), .rw_n(rw_n), .cyc_type(cyc_type),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  assign rdata = mem(addr);

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      report();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected bus cycle from the ordering rules (R2, R3, R4, R5, R10, R11)
  task automatic check_step(input logic m, input int s, input logic [15:0] p, input logic [7:0] sp0);
    logic [15:0] ret, ea;
    logic        er;
    logic [2:0]  et;
    logic [7:0]  ed;
    string       tag;
    ret = p + 16'd2;
    ed  = 8'h00;
    er  = 1'b1;
    case ({m, 3'(s)})
      4'h0, 4'h8: begin ea = p;          et = 3'd1; tag = "R10 opcode"; end
      4'h1, 4'h9: begin ea = p + 16'd1;  et = 3'd2; tag = "R11 operand lo"; end
      4'h5, 4'hA: begin ea = p + 16'd2;  et = 3'd2; tag = "R11 operand hi"; end
      4'h2, 4'hB: begin ea = {8'h01, sp0}; et = 3'd3; tag = "R5 dummy"; end
      4'h3, 4'hC: begin ea = {8'h01, sp0}; et = 3'd4; er = 1'b0; ed = ret[15:8]; tag = "R4 push hi"; end
      default:    begin ea = {8'h01, sp0 - 8'd1}; et = 3'd4; er = 1'b0; ed = ret[7:0]; tag = "R4 push lo"; end
    endcase
    tag = {tag, m ? " R3/R7/R8" : " R2/R8"};
    check(tag, {addr, wdata, rw_n, cyc_type, 5'd0}, {ea, ed, er, et, 5'd0});
  endtask

  task automatic run_call(input logic m, input logic [15:0] p, input logic [7:0] sp0, input logic stray);
    @(negedge clk);
    start = 1'b1; start_pc = p; start_sp = sp0; mode_alt = m;
    @(negedge clk);
    start = 1'b0; start_pc = ~p; start_sp = ~sp0;
    check_step(m, 0, p, sp0);
    for (int s = 1; s < 6; s++) begin
      @(negedge clk);
      check_step(m, s, p, sp0);
      if (s == 1) mode_alt = ~m;            // R8: late change ignored
      if (s == 2 && stray) start = 1'b1;    // R9: start while busy
      if (s == 3) start = 1'b0;
    end
    @(negedge clk);
    check("R6/R9 done/busy", {30'd0, done, busy}, 32'd2);
    check("R6/R9 pc_out", {16'd0, pc_out}, {16'd0, mem(p + 16'd2), mem(p + 16'd1)});
    check("R4/R6 sp_out", {24'd0, sp_out}, {24'd0, sp0 - 8'd2});
    @(negedge clk);
    check("R6 done falls", {29'd0, done, cyc_type[1:0]}, 32'd0);
  endtask

  initial begin
    #2;
    check("R1 reset", {28'd0, busy, done, rw_n, |cyc_type}, 32'h2);
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {26'd0, busy, done, rw_n, cyc_type}, 32'h8);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        run_call(m[0], {8'(i) ^ 8'hA5, 8'(i * 7)}, 8'(i), i[0]);
      end
      // R11 wrap corners
      run_call(m[0], 16'hFFFE, 8'h00, 1'b1);
      run_call(m[0], 16'hFFFF, 8'h01, 1'b0);
      run_call(m[0], 16'h00FE, 8'hFF, 1'b1);
    end
    report();
  end
endmodule